// File: doc/BRIEF.md
# Random-Pattern Comparison Test Controller

The block runs a go/no-go test on an external unit by driving it and a fault-free reference unit with the same pseudo-random pattern in the same cycle. The pattern comes from a maximal-length linear feedback shift register, which is loaded from a seed input on every start. Each run can therefore use a different sequence, and the comparison logic stays the same whatever sequence is chosen. A programmable count sets how many patterns a run issues.

The two response words are sampled a fixed, parameterised number of cycles after their pattern was driven, so pipelined units can be tested. The first disagreement sets a sticky error flag and captures the index of the failing pattern and the word the unit under test returned for it. When the last response has been compared, the block raises done with a pass/fail verdict. These results hold until the next start. The block does not try to locate the fault.

Top module: `rpct_top`

## Requirements
- R1: Out of reset, pat_valid, busy, done, pass and err are all 0.
- R2: When start is seen at a clock edge, the pattern driven in the next cycle (index 0) equals seed. A seed of 0 is replaced by the value 1.
- R3: Each later pattern is the previous one shifted left by one bit, with a new LSB equal to the XOR of the feedback taps. For the 8-bit width the taps are bits 7, 5, 4 and 3, which gives a period of 255.
- R4: After a start with count N greater than 0, pat_valid is high for exactly N consecutive cycles, starting in the cycle after start.
- R5: The responses on dut_rsp and ref_rsp are compared in the cycle LATENCY cycles after their pattern was driven. Response values in cycles with no pattern in flight are ignored.
- R6: The first mismatch sets err in the following cycle and latches fail_idx (the pattern index, 0-based) and fail_rsp (the dut_rsp word). err, fail_idx and fail_rsp do not change again until the next start.
- R7: done rises in cycle N+LATENCY+1 after the start edge, with busy low. pass is 1 only if no compared response mismatched. done and pass hold until the next start.
- R8: A start with count 0 issues no pattern and gives done=1 and pass=1 in the next cycle.
- R9: A start accepted during a run abandons that run. In the next cycle err and done are 0 and the new sequence begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (one-cycle pulse) |
| seed | input | PAT_W | Generator seed captured on start |
| pat_count | input | CNT_W | Number of patterns in the run |
| pattern | output | PAT_W | Pattern driven to both units |
| pat_valid | output | 1 | pattern carries a test vector this cycle |
| dut_rsp | input | RSP_W | Response of the unit under test |
| ref_rsp | input | RSP_W | Response of the reference unit |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished |
| pass | output | 1 | Verdict, valid while done is high |
| err | output | 1 | Sticky mismatch flag |
| fail_idx | output | CNT_W | Index of the first failing pattern |
| fail_rsp | output | RSP_W | dut_rsp word at the first failure |

## Verification
Runs with several seeds, including zero, check the generated sequence and the pattern count. A full 256-pattern run shows the period of 255. Faults are injected at index 0, at the last index and at two middle indices, which tells first-error capture apart from later overwrite, shows the latency window is aligned at both of its ends, and shows the verdict follows a fault at the very last compare. The unit under test returns corrupted words whenever no pattern is in flight, so any compare outside the window would show up. A zero-length run and a restart in the middle of a failing run cover the control corners.

// File: rtl/rpct_pkg.sv
package rpct_pkg;

   localparam int unsigned LFSR_MIN_W = 3;
   localparam int unsigned LFSR_MAX_W = 16;

   // Feedback tap mask for a maximal-length Fibonacci shift register,
   // bit k set means state bit k enters the XOR.
   function automatic logic [15:0] lfsr_taps(input int unsigned w);
      logic [15:0] m;
      case (w)
         3:  m = 16'h0006;
         4:  m = 16'h000C;
         5:  m = 16'h0014;
         6:  m = 16'h0030;
         7:  m = 16'h0060;
         8:  m = 16'h00B8;
         9:  m = 16'h0110;
         10: m = 16'h0240;
         11: m = 16'h0500;
         12: m = 16'h0829;
         13: m = 16'h100D;
         14: m = 16'h2015;
         15: m = 16'h6000;
         16: m = 16'hD008;
         default: m = 16'h0000;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/rpct_lfsr.sv
module rpct_lfsr #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] seed,
   input  logic         step,
   output logic [W-1:0] state
);
   import rpct_pkg::*;

   localparam logic [15:0]  TAPS_ALL = lfsr_taps(W);
   localparam logic [W-1:0] TAP_MASK = TAPS_ALL[W-1:0];
   localparam logic [W-1:0] SEED_SUB = {{(W-1){1'b0}}, 1'b1};

   generate
      if (W < LFSR_MIN_W || W > LFSR_MAX_W) begin : g_bad_width
         $error("rpct_lfsr: width out of supported range");
      end
   endgenerate

   logic [W-1:0] nxt;
   logic         fb;

   always_comb begin
      fb  = ^(state & TAP_MASK);
      nxt = {state[W-2:0], fb};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        state <= SEED_SUB;
      else if (load)     state <= (seed == '0) ? SEED_SUB : seed;
      else if (step)     state <= nxt;
   end

   // R2/R3: a maximal-length register never reaches the all-zero lock-up state
   a_r3_no_lockup: assert property (@(posedge clk) disable iff (!rst_n)
      state != '0);

endmodule

// File: rtl/rpct_delay.sv
module rpct_delay #(
   parameter int unsigned LAT = 2,
   parameter int unsigned IW  = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          vld_i,
   input  logic [IW-1:0] idx_i,
   output logic          vld_o,
   output logic [IW-1:0] idx_o
);
   generate
      if (LAT == 0) begin : g_direct
         assign vld_o = vld_i;
         assign idx_o = idx_i;
      end else begin : g_pipe
         logic          vld_sr [LAT];
         logic [IW-1:0] idx_sr [LAT];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int k = 0; k < LAT; k++) begin
                  vld_sr[k] <= 1'b0;
                  idx_sr[k] <= '0;
               end
            end else if (clr) begin
               for (int k = 0; k < LAT; k++) begin
                  vld_sr[k] <= 1'b0;
                  idx_sr[k] <= '0;
               end
            end else begin
               vld_sr[0] <= vld_i;
               idx_sr[0] <= idx_i;
               for (int k = 1; k < LAT; k++) begin
                  vld_sr[k] <= vld_sr[k-1];
                  idx_sr[k] <= idx_sr[k-1];
               end
            end
         end

         assign vld_o = vld_sr[LAT-1];
         assign idx_o = idx_sr[LAT-1];

         // R5: no compare slot appears without a pattern LAT cycles earlier
         a_r5_window_aligned: assert property (@(posedge clk) disable iff (!rst_n)
            (vld_sr[0] && !clr) |-> $past(vld_i));
      end
   endgenerate

endmodule

// File: rtl/rpct_cmp.sv
module rpct_cmp #(
   parameter int unsigned RW = 8,
   parameter int unsigned IW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          vld,
   input  logic [IW-1:0] idx,
   input  logic [RW-1:0] dut_rsp,
   input  logic [RW-1:0] ref_rsp,
   output logic          mis,
   output logic          err,
   output logic [IW-1:0] fail_idx,
   output logic [RW-1:0] fail_rsp
);
   assign mis = vld && (dut_rsp != ref_rsp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err      <= 1'b0;
         fail_idx <= '0;
         fail_rsp <= '0;
      end else if (clr) begin
         err      <= 1'b0;
         fail_idx <= '0;
         fail_rsp <= '0;
      end else if (mis && !err) begin
         err      <= 1'b1;
         fail_idx <= idx;
         fail_rsp <= dut_rsp;
      end
   end

   // R6: the flag stays set until a new run clears it
   a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !clr) |=> err);

   // R6: the first-failure record is never overwritten by later mismatches
   a_r6_capture_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !clr) |=> ($stable(fail_idx) && $stable(fail_rsp)));

endmodule

// File: rtl/rpct_top.sv
module rpct_top #(
   parameter int unsigned PAT_W   = 8,
   parameter int unsigned RSP_W   = 8,
   parameter int unsigned CNT_W   = 12,
   parameter int unsigned LATENCY = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [PAT_W-1:0] seed,
   input  logic [CNT_W-1:0] pat_count,
   output logic [PAT_W-1:0] pattern,
   output logic             pat_valid,
   input  logic [RSP_W-1:0] dut_rsp,
   input  logic [RSP_W-1:0] ref_rsp,
   output logic             busy,
   output logic             done,
   output logic             pass,
   output logic             err,
   output logic [CNT_W-1:0] fail_idx,
   output logic [RSP_W-1:0] fail_rsp
);
   localparam int unsigned MAX_LAT = 16;

   generate
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
         $error("rpct_top: CNT_W out of range");
      end
      if (RSP_W < 1) begin : g_bad_rsp
         $error("rpct_top: RSP_W must be positive");
      end
      if (LATENCY > MAX_LAT) begin : g_bad_lat
         $error("rpct_top: LATENCY too large");
      end
   endgenerate

   logic [CNT_W-1:0] len_q;
   logic [CNT_W-1:0] idx_q;
   logic [CNT_W-1:0] len_m1;
   logic             pv_q;
   logic             busy_q;
   logic             done_q;
   logic             pass_q;
   logic             at_last;
   logic             lat_vld;
   logic [CNT_W-1:0] lat_idx;
   logic             cmp_mis;
   logic             cmp_err;
   logic             final_cmp;

   assign len_m1    = len_q - 1'b1;
   assign at_last   = (idx_q == len_m1);
   assign final_cmp = lat_vld && (lat_idx == len_m1);

   rpct_lfsr #(.W(PAT_W)) u_gen (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (start),
      .seed  (seed),
      .step  (pv_q && !at_last),
      .state (pattern)
   );

   rpct_delay #(.LAT(LATENCY), .IW(CNT_W)) u_dly (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (start),
      .vld_i (pv_q),
      .idx_i (idx_q),
      .vld_o (lat_vld),
      .idx_o (lat_idx)
   );

   rpct_cmp #(.RW(RSP_W), .IW(CNT_W)) u_cmp (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (start),
      .vld      (lat_vld),
      .idx      (lat_idx),
      .dut_rsp  (dut_rsp),
      .ref_rsp  (ref_rsp),
      .mis      (cmp_mis),
      .err      (cmp_err),
      .fail_idx (fail_idx),
      .fail_rsp (fail_rsp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_q  <= '0;
         idx_q  <= '0;
         pv_q   <= 1'b0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
         pass_q <= 1'b0;
      end else if (start) begin
         len_q  <= pat_count;
         idx_q  <= '0;
         pv_q   <= (pat_count != '0);
         busy_q <= (pat_count != '0);
         done_q <= (pat_count == '0);
         pass_q <= (pat_count == '0);
      end else begin
         if (pv_q) begin
            if (at_last) pv_q  <= 1'b0;
            else         idx_q <= idx_q + 1'b1;
         end
         if (final_cmp) begin
            done_q <= 1'b1;
            busy_q <= 1'b0;
            pass_q <= !(cmp_err || cmp_mis);
         end
      end
   end

   assign pat_valid = pv_q;
   assign busy      = busy_q;
   assign done      = done_q;
   assign pass      = pass_q;
   assign err       = cmp_err;

   // R7: a finished run holds its verdict until restarted
   a_r7_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> (done && $stable(pass)));

   // R7: a finished run is neither busy nor issuing patterns
   a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && !pat_valid));

   // R7: a passing verdict never coexists with a recorded mismatch
   a_r7_pass_clean: assert property (@(posedge clk) disable iff (!rst_n)
      (done && pass) |-> !err);

   // R9: a start clears the previous outcome in the next cycle
   a_r9_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (start && pat_count != '0) |=> (!err && !done && pat_valid));

endmodule

// File: tb/rpct_top_tb.sv
module rpct_top_tb_top;
   localparam int PW  = 8;
   localparam int RW  = 8;
   localparam int CW  = 12;
   localparam int LAT = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [PW-1:0] seed = '0;
   logic [CW-1:0] pat_count = '0;
   logic [PW-1:0] pattern;
   logic          pat_valid;
   logic [RW-1:0] dut_rsp;
   logic [RW-1:0] ref_rsp;
   logic          busy, done, pass, err;
   logic [CW-1:0] fail_idx;
   logic [RW-1:0] fail_rsp;

   int checks = 0;
   int errors = 0;
   int fault_a = -1;
   int fault_b = -1;

   logic [PW-1:0] got_pat [0:511];

   always #2 clk = ~clk;

   rpct_top #(.PAT_W(PW), .RSP_W(RW), .CNT_W(CW), .LATENCY(LAT)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .seed(seed), .pat_count(pat_count),
      .pattern(pattern), .pat_valid(pat_valid), .dut_rsp(dut_rsp), .ref_rsp(ref_rsp),
      .busy(busy), .done(done), .pass(pass), .err(err),
      .fail_idx(fail_idx), .fail_rsp(fail_rsp)
   );

   function automatic logic [RW-1:0] fmap(input logic [PW-1:0] p);
      return {p[3:0], p[7:4]} ^ 8'h5A;
   endfunction

   function automatic logic [PW-1:0] lfsr_nxt(input logic [PW-1:0] s);
      return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
   endfunction

   // Model of the two external units: two-stage pipelines (LAT = 2)
   int            vcnt = 0;
   logic [PW-1:0] p1 = '0, p2 = '0;
   logic          v1 = 1'b0, v2 = 1'b0;
   int            i1 = 0, i2 = 0;

   always @(posedge clk) begin
      if (start)          vcnt <= 0;
      else if (pat_valid) vcnt <= vcnt + 1;
      p1 <= pattern;   v1 <= pat_valid; i1 <= vcnt;
      p2 <= p1;        v2 <= v1;        i2 <= i1;
   end

   always_comb begin
      ref_rsp = fmap(p2);
      if (!v2)                              dut_rsp = ~fmap(p2);
      else if (i2 == fault_a || i2 == fault_b) dut_rsp = fmap(p2) ^ 8'h01;
      else                                  dut_rsp = fmap(p2);
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic run_test(input logic [PW-1:0] sd, input int n,
                           input int fa, input int fb, input string tag);
      logic [PW-1:0] model;
      int nv, seq_bad, done_cyc, first_f;
      bit  exp_fail;
      fault_a = fa;
      fault_b = fb;
      @(negedge clk);
      start = 1'b1; seed = sd; pat_count = CW'(n);
      @(negedge clk);
      start = 1'b0;
      // R9: previous outcome cleared in the first cycle of the run
      chk(!err && (done == (n == 0)), "R9", {tag, " clear on start"}, int'(err), 0);
      model    = (sd == 0) ? 8'h01 : sd;
      nv       = 0;
      seq_bad  = 0;
      done_cyc = -1;
      for (int cyc = 1; cyc <= n + LAT + 8; cyc++) begin
         if (pat_valid) begin
            got_pat[nv] = pattern;
            if (pattern !== model) seq_bad++;
            if (nv == 0)
               chk(pattern == ((sd == 0) ? 8'h01 : sd), "R2", {tag, " first pattern"},
                   int'(pattern), int'((sd == 0) ? 8'h01 : sd));
            model = lfsr_nxt(model);
            nv++;
         end
         if (done && done_cyc < 0) done_cyc = cyc;
         if (done_cyc >= 0) break;
         @(negedge clk);
      end
      chk(seq_bad == 0, "R3", {tag, " sequence errors"}, seq_bad, 0);
      chk(nv == n, "R4", {tag, " pattern count"}, nv, n);
      chk(done_cyc == ((n == 0) ? 1 : n + LAT + 1), "R7", {tag, " done cycle"},
          done_cyc, (n == 0) ? 1 : n + LAT + 1);
      chk(!busy, "R7", {tag, " busy after done"}, int'(busy), 0);
      first_f = -1;
      if (fa >= 0 && fa < n) first_f = fa;
      if (fb >= 0 && fb < n && (first_f < 0 || fb < first_f)) first_f = fb;
      exp_fail = (first_f >= 0);
      chk(pass == !exp_fail, "R7", {tag, " verdict"}, int'(pass), int'(!exp_fail));
      chk(err == exp_fail, "R6", {tag, " error flag"}, int'(err), int'(exp_fail));
      if (exp_fail) begin
         chk(fail_idx == CW'(first_f), "R6", {tag, " fail index"}, int'(fail_idx), first_f);
         chk(fail_rsp == (fmap(got_pat[first_f]) ^ 8'h01), "R6", {tag, " fail response"},
             int'(fail_rsp), int'(fmap(got_pat[first_f]) ^ 8'h01));
      end
      // R7: verdict holds while idle (R5: stray responses keep arriving corrupted)
      repeat (5) @(negedge clk);
      chk(done && pass == !exp_fail, "R7", {tag, " verdict held"}, int'(pass), int'(!exp_fail));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=expired expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!pat_valid && !busy && !done && !pass && !err, "R1", "reset outputs",
          int'({pat_valid, busy, done, pass, err}), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      // R5: corrupted responses with no pattern in flight are ignored
      chk(!err, "R5", "idle mismatch ignored", int'(err), 0);

      run_test(8'hA5, 20, -1, -1, "clean");
      run_test(8'h00, 5, -1, -1, "zero seed");
      run_test(8'h3C, 50, 17, 30, "two faults");
      run_test(8'h77, 12, 11, -1, "fault last");
      run_test(8'h91, 9, 0, 5, "fault first");
      run_test(8'h4E, 0, -1, -1, "R8 zero count");
      chk(!pat_valid, "R8", "no pattern for count 0", int'(pat_valid), 0);

      // R9: restart in the middle of a failing run
      fault_a = 3; fault_b = -1;
      @(negedge clk);
      start = 1'b1; seed = 8'h11; pat_count = 12'd40;
      @(negedge clk);
      start = 1'b0;
      repeat (12) @(negedge clk);
      chk(err && busy, "R9", "mid-run error seen", int'(err), 1);
      run_test(8'h22, 10, -1, -1, "restart");

      // R3: full period, 8-bit sequence repeats after 255 patterns
      run_test(8'h01, 256, -1, -1, "period");
      begin
         bit seen [256];
         int dup = 0;
         for (int k = 0; k < 256; k++) seen[k] = 1'b0;
         for (int k = 0; k < 255; k++) begin
            if (seen[got_pat[k]]) dup++;
            seen[got_pat[k]] = 1'b1;
         end
         chk(dup == 0, "R3", "distinct patterns in period", dup, 0);
         chk(got_pat[255] == got_pat[0], "R3", "wrap after 255",
             int'(got_pat[255]), int'(got_pat[0]));
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule